// File: doc/BRIEF.md
# Criticality-Steered Dual-Latency Link

This block carries transfers from one sending cluster of a clustered out-of-order core to one destination. It has two parallel channels. The fast channel is tuned for delay. The slow channel is tuned for power and takes twice as long to deliver. Each transfer comes with a kind code, and bypassed register values also carry a criticality hint. From these the block picks one channel. Latency-tolerant traffic goes on the cheap wires, and traffic on the critical path keeps the short delay.

Each channel is a fixed-depth delay pipeline that accepts one transfer per cycle and delivers the payload and tag on the far side. The data registers in each stage load only when a valid transfer enters that stage. Two saturating counters record how many transfers each channel has accepted. A synchronous reset empties both pipelines and clears both counters.

Top module: `xlink_dual_lat_link`

## Requirements
- R1: A transfer with kind 5 (load value) always goes on the fast channel.
- R2: A transfer with kind 4 (store value) always goes on the slow channel.
- R3: A transfer with kind 2 (register already ready at dispatch) goes on the slow channel.
- R4: A transfer with kind 3 (bypassed register) goes on the fast channel when `req_crit` is 1 and on the slow channel when `req_crit` is 0.
- R5: Kind 0 (address that was not predicted) goes on the fast channel. Kind 1 (check of a predicted address) goes on the slow channel.
- R6: A transfer sampled at a rising edge shows up on its channel's outputs with unchanged data and tag after exactly FAST_LAT edges (default 2) on the fast channel, or 2*FAST_LAT edges (default 4) on the slow channel. Its output valid is high for one cycle.
- R7: Each channel accepts a new transfer every cycle. Back-to-back transfers come out in the order they went in. No transfer appears on both channels.
- R8: `fast_count` and `slow_count` (16 bits) each add one for every transfer accepted onto their channel, starting at the next edge. They stop at 65535.
- R9: A cycle with `req_valid` low produces no output valid on either channel and leaves both counters unchanged.
- R10: When `rst` is high at a rising edge, both output valids and both counters are 0 after that edge. Transfers still in flight are dropped.
- R11: `req_crit` has no effect on kinds other than 3. The unused kinds 6 and 7 go on the fast channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Transfer present this cycle |
| req_kind | input | 3 | Transfer kind code (see R1 to R5, R11) |
| req_crit | input | 1 | Criticality hint, used for kind 3 only |
| req_data | input | DATA_W (32) | Payload |
| req_tag | input | TAG_W (8) | Destination tag |
| fast_valid | output | 1 | Fast channel delivers this cycle |
| fast_data | output | DATA_W (32) | Fast channel payload |
| fast_tag | output | TAG_W (8) | Fast channel tag |
| slow_valid | output | 1 | Slow channel delivers this cycle |
| slow_data | output | DATA_W (32) | Slow channel payload |
| slow_tag | output | TAG_W (8) | Slow channel tag |
| fast_count | output | CNT_W (16) | Transfers accepted on the fast channel |
| slow_count | output | CNT_W (16) | Transfers accepted on the slow channel |

## Verification
The bench sends every kind code with both values of the hint. A routing table that treats the bypass hint as critical for every kind, or that sends a load down the slow channel, would deliver to the wrong side or two cycles late. A dense random stream with back-to-back transfers on both channels exposes an off-by-one pipeline depth or a stage that drops data when it is full. More than 65535 loads in a row push the fast counter to its limit: a counter without saturation would wrap to zero, and a mis-gated one would also move the slow count. A reset while both pipelines are full must drop everything in flight, and loads sent with valid low must leave no trace in the outputs or the counters.

// File: rtl/xlink_pkg.sv
package xlink_pkg;

  typedef enum logic [2:0] {
    XK_ADDR_UNPRED = 3'd0,
    XK_ADDR_VERIFY = 3'd1,
    XK_REG_READY   = 3'd2,
    XK_REG_BYPASS  = 3'd3,
    XK_STORE_VAL   = 3'd4,
    XK_LOAD_VAL    = 3'd5
  } xfer_kind_e;

  // Channel choice: 1 selects the power-optimized (slow) channel.
  function automatic logic wants_slow(input logic [2:0] kind, input logic crit);
    logic slow;
    case (kind)
      XK_ADDR_VERIFY: slow = 1'b1;
      XK_REG_READY:   slow = 1'b1;
      XK_STORE_VAL:   slow = 1'b1;
      XK_REG_BYPASS:  slow = ~crit;
      default:        slow = 1'b0;
    endcase
    return slow;
  endfunction

endpackage

// File: rtl/xlink_steer.sv
module xlink_steer
  import xlink_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [2:0] in_kind,
  input  logic       in_crit,
  output logic       to_fast,
  output logic       to_slow
);

  logic pick_slow;

  always_comb begin
    pick_slow = wants_slow(in_kind, in_crit);
    to_fast   = in_valid & ~pick_slow;
    to_slow   = in_valid &  pick_slow;
  end

  AST_LOAD_FAST: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 3'd5) |-> (to_fast && !to_slow)); // R1
  AST_STORE_SLOW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 3'd4) |-> (to_slow && !to_fast)); // R2
  AST_READY_SLOW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 3'd2) |-> to_slow); // R3
  AST_BYPASS_HINT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 3'd3) |-> (to_fast == in_crit)); // R4
  AST_ADDR_SPLIT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind <= 3'd1) |-> (to_slow == in_kind[0])); // R5
  AST_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({to_fast, to_slow})); // R7
  AST_IDLE_NO_LANE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> (!to_fast && !to_slow)); // R9
  AST_SPARE_FAST: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind >= 3'd6) |-> to_fast); // R11

endmodule

// File: rtl/xlink_delay_pipe.sv
module xlink_delay_pipe #(
  parameter int DEPTH = 2,
  parameter int W     = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  logic [DEPTH-1:0] vld_q;
  logic [W-1:0]     dat_q [DEPTH];
  logic [DEPTH-1:0] nxt_v;
  logic [W-1:0]     nxt_d [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign nxt_v[i] = in_valid;
      assign nxt_d[i] = in_data;
    end else begin : g_body
      assign nxt_v[i] = vld_q[i-1];
      assign nxt_d[i] = dat_q[i-1];

      AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        vld_q[i-1] |=> (vld_q[i] && dat_q[i] == $past(dat_q[i-1]))); // R6
    end
  end

  // Valid bits reset; data registers load only with a valid beat.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst) vld_q[i] <= 1'b0;
      else     vld_q[i] <= nxt_v[i];
      if (nxt_v[i]) dat_q[i] <= nxt_d[i];
    end
  end

  assign out_valid = vld_q[DEPTH-1];
  assign out_data  = dat_q[DEPTH-1];

  AST_RESET_EMPTIES: assert property (@(posedge clk)
    rst |=> (vld_q == '0)); // R10

endmodule

// File: rtl/xlink_sat_counter.sv
module xlink_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  function automatic logic [W-1:0] sat_next(input logic [W-1:0] cur, input logic bump);
    return (bump && cur != TOP) ? cur + 1'b1 : cur;
  endfunction

  logic [W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= sat_next(count_q, inc);
  end

  assign count = count_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (count_q == TOP) |=> (count_q == TOP)); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (inc && count_q != TOP) |=> (count_q == $past(count_q) + 1'b1)); // R8
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(count_q)); // R9

endmodule

// File: rtl/xlink_dual_lat_link.sv
module xlink_dual_lat_link #(
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 8,
  parameter int FAST_LAT = 2,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic              req_crit,
  input  logic [DATA_W-1:0] req_data,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              fast_valid,
  output logic [DATA_W-1:0] fast_data,
  output logic [TAG_W-1:0]  fast_tag,
  output logic              slow_valid,
  output logic [DATA_W-1:0] slow_data,
  output logic [TAG_W-1:0]  slow_tag,
  output logic [CNT_W-1:0]  fast_count,
  output logic [CNT_W-1:0]  slow_count
);

  localparam int SLOW_LAT = 2 * FAST_LAT;
  localparam int PKT_W    = DATA_W + TAG_W;

  logic             steer_fast;
  logic             steer_slow;
  logic [PKT_W-1:0] req_pkt;
  logic [PKT_W-1:0] fast_pkt;
  logic [PKT_W-1:0] slow_pkt;

  assign req_pkt = {req_tag, req_data};

  xlink_steer u_steer (
    .clk      (clk),
    .rst      (rst),
    .in_valid (req_valid),
    .in_kind  (req_kind),
    .in_crit  (req_crit),
    .to_fast  (steer_fast),
    .to_slow  (steer_slow)
  );

  xlink_delay_pipe #(.DEPTH(FAST_LAT), .W(PKT_W)) u_fast_pipe (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (steer_fast),
    .in_data   (req_pkt),
    .out_valid (fast_valid),
    .out_data  (fast_pkt)
  );

  xlink_delay_pipe #(.DEPTH(SLOW_LAT), .W(PKT_W)) u_slow_pipe (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (steer_slow),
    .in_data   (req_pkt),
    .out_valid (slow_valid),
    .out_data  (slow_pkt)
  );

  xlink_sat_counter #(.W(CNT_W)) u_fast_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (steer_fast),
    .count (fast_count)
  );

  xlink_sat_counter #(.W(CNT_W)) u_slow_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (steer_slow),
    .count (slow_count)
  );

  assign {fast_tag, fast_data} = fast_pkt;
  assign {slow_tag, slow_data} = slow_pkt;

  AST_IDLE_COUNTS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(fast_count) && $stable(slow_count))); // R9
  AST_RESET_COUNTS: assert property (@(posedge clk)
    rst |=> (fast_count == '0 && slow_count == '0)); // R10

endmodule

// File: tb/xlink_dual_lat_link_test.sv
`timescale 1ns/1ps
module xlink_dual_lat_link_test;

  localparam int FL = 2;
  localparam int SL = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [2:0]  req_kind;
  logic        req_crit;
  logic [31:0] req_data;
  logic [7:0]  req_tag;
  logic        fast_valid, slow_valid;
  logic [31:0] fast_data, slow_data;
  logic [7:0]  fast_tag, slow_tag;
  logic [15:0] fast_count, slow_count;

  always #2 clk = ~clk;

  xlink_dual_lat_link uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_crit(req_crit), .req_data(req_data), .req_tag(req_tag),
    .fast_valid(fast_valid), .fast_data(fast_data), .fast_tag(fast_tag),
    .slow_valid(slow_valid), .slow_data(slow_data), .slow_tag(slow_tag),
    .fast_count(fast_count), .slow_count(slow_count)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  int n     = 0;

  logic        hv [256];
  logic [2:0]  hk [256];
  logic        hc [256];
  logic [31:0] hd [256];
  logic [7:0]  ht [256];
  logic [15:0] m_fast, m_slow;

  // Independent restatement of the routing rules.
  function automatic bit goes_fast(input logic [2:0] k, input logic c);
    if (k == 3'd5 || k == 3'd0 || k == 3'd6 || k == 3'd7) return 1'b1;
    if (k == 3'd3) return c;
    return 1'b0;
  endfunction

  function automatic string req_of(input logic [2:0] k);
    case (k)
      3'd0, 3'd1: return "R5";
      3'd2:       return "R3";
      3'd3:       return "R4";
      3'd4:       return "R2";
      3'd5:       return "R1";
      default:    return "R11";
    endcase
  endfunction

  function automatic logic [15:0] sat_add(input logic [15:0] v);
    return (v == 16'hFFFF) ? v : v + 16'd1;
  endfunction

  task automatic check(input string r, input string what, input logic [39:0] act, input logic [39:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic check_lane(input bit fast_side, input int lat);
    int   idx;
    logic ev;
    string r;
    logic a_v;
    logic [39:0] a_p;
    ev = 1'b0;
    r  = "R9";
    idx = (n - lat) & 255;
    if (n >= lat && hv[idx]) begin
      r  = req_of(hk[idx]);
      ev = (goes_fast(hk[idx], hc[idx]) == fast_side);
    end
    a_v = fast_side ? fast_valid : slow_valid;
    a_p = fast_side ? {fast_tag, fast_data} : {slow_tag, slow_data};
    check(r, fast_side ? "fast_valid" : "slow_valid", {39'd0, a_v}, {39'd0, ev});
    if (ev && a_v) check("R6", fast_side ? "fast payload" : "slow payload",
                         a_p, {ht[idx], hd[idx]});
  endtask

  task automatic cyc(input logic v, input logic [2:0] k, input logic c,
                     input logic [31:0] d, input logic [7:0] t);
    @(negedge clk);
    check_lane(1'b1, FL);
    check_lane(1'b0, SL);
    check("R8", "fast_count", {24'd0, fast_count}, {24'd0, m_fast});
    check("R8", "slow_count", {24'd0, slow_count}, {24'd0, m_slow});
    hv[n & 255] = v; hk[n & 255] = k; hc[n & 255] = c;
    hd[n & 255] = d; ht[n & 255] = t;
    req_valid = v; req_kind = k; req_crit = c; req_data = d; req_tag = t;
    if (v) begin
      if (goes_fast(k, c)) m_fast = sat_add(m_fast);
      else                 m_slow = sat_add(m_slow);
    end
    n++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 256; i++) hv[i] = 1'b0;
    n = 0; m_fast = '0; m_slow = '0;
    // R10: state right after the reset edges
    check("R10", "fast_valid after reset", {39'd0, fast_valid}, 40'd0);
    check("R10", "slow_valid after reset", {39'd0, slow_valid}, 40'd0);
    check("R10", "fast_count after reset", {24'd0, fast_count}, 40'd0);
    check("R10", "slow_count after reset", {24'd0, slow_count}, 40'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; req_valid = 1'b0; req_kind = '0; req_crit = 1'b0;
    req_data = '0; req_tag = '0;
    m_fast = '0; m_slow = '0;
    do_reset();

    // Directed: every kind with both hint values, back to back (R1..R5, R11, R7)
    for (int k = 0; k < 8; k++) begin
      cyc(1'b1, 3'(k), 1'b0, 32'hA000_0000 + k, 8'(k));
      cyc(1'b1, 3'(k), 1'b1, 32'hB000_0000 + k, 8'(k + 16));
    end
    // R9: loads with valid low, then drain
    for (int i = 0; i < 4; i++) cyc(1'b0, 3'd5, 1'b1, 32'hDEAD_0000 + i, 8'hEE);
    for (int i = 0; i < 6; i++) cyc(1'b0, 3'd0, 1'b0, 32'd0, 8'd0);

    // Constrained random mix
    for (int i = 0; i < 3000; i++)
      cyc(($urandom % 4) != 0, 3'($urandom % 8), 1'($urandom % 2), $urandom, 8'($urandom));

    // R10: reset with both pipelines full, then observe drain window
    for (int i = 0; i < 6; i++) cyc(1'b1, 3'(i % 6), 1'b0, 32'hC0DE_0000 + i, 8'(i));
    do_reset();
    for (int i = 0; i < 6; i++) cyc(1'b0, 3'd0, 1'b0, 32'd0, 8'd0);

    // R8: saturate fast counter with loads; slow count must not move
    for (int i = 0; i < 65540; i++) cyc(1'b1, 3'd5, 1'b0, i, 8'(i));
    for (int i = 0; i < 3; i++) cyc(1'b1, 3'd5, 1'b0, 32'h1234_5678, 8'h5A);
    cyc(1'b0, 3'd0, 1'b0, 32'd0, 8'd0);
    check("R8", "fast_count saturated", {24'd0, fast_count}, {24'd0, 16'hFFFF});
    check("R8", "slow_count untouched", {24'd0, slow_count}, 40'd0);
    for (int i = 0; i < 8; i++) cyc(1'b1, 3'd4, 1'b0, 32'h5700_0000 + i, 8'(i));
    for (int i = 0; i < 6; i++) cyc(1'b0, 3'd0, 1'b0, 32'd0, 8'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule